// File: doc/BRIEF.md
# Oversampling Serial Receiver with In-Frame Phase Realignment

This block receives asynchronous serial characters: one start bit, eight or nine data bits sent least significant bit first, and one stop bit. It watches the receive line only on a receive-time tick enable supplied by an external rate generator. That tick runs sixteen times per bit period, so each bit spans sixteen phases, numbered 1 to 16. Each bit is decided by a two-out-of-three vote over the line levels seen at phases 8, 9 and 10. The result is delivered with a one-cycle strobe, together with a noise indication and a framing-error indication.

While a frame is in progress, the receiver realigns its phase counter on every usable falling edge of the line. The transmitter's edges therefore pull the sampling points back to mid-bit, and a rate mismatch of a few percent between transmitter and receiver does no harm. The stop bit is sampled at phases 8 to 10 like any other bit. A frame whose stop bit starts late, or ends early, is still received cleanly as long as those three samples see the idle level.

Top module: `uart_os_rx`

## Requirements
- R1: In idle, a frame begins on the first RT tick at which `rx_in` is 0 while it was 1 at the previous RT tick; that tick is phase 1 of the start bit.
- R2: Each bit's value is the majority of the line levels at phases 8, 9 and 10 of that bit.
- R3: If the start bit's majority is 1, the receiver returns to idle and emits no strobe; a valid frame that follows is then received normally.
- R4: Data bits are stored least significant bit first into `rx_word[0]` upward. `long_char` = 1 selects 9 data bits; `long_char` = 0 selects 8 data bits, and `rx_word[8]` then reads 0. The mode is captured at the start bit.
- R5: Counting the start tick as tick 0, the stop bit is decided at tick 153 for 8-bit characters and at tick 169 for 9-bit characters, in an unskewed frame. `rx_valid` is high for exactly one clock cycle, in the cycle after that tick's clock edge.
- R6: `noise_err` is 1 for a frame in which the three samples of any bit (start, data or stop) were not all equal; otherwise it is 0.
- R7: `frame_err` is 1 when the stop bit's majority is 0. The data word is still delivered with the strobe.
- R8: Inside a frame, a falling edge seen at phases 1 to 7 makes that tick phase 1 of the current bit. One seen at phases 11 to 16 makes it phase 1 of the next bit. One seen at phases 8 to 10 does not move the phase.
- R9: With realignment, frames whose bits last 15 or 17 RT ticks and carry data 0x55 are received without noise or framing error.
- R10: After reset `rx_word`, `noise_err`, `frame_err` and `rx_valid` are 0. Word and flags hold their values between strobes.
- R11: Receiver state advances only on clock edges where `rt_tick` is 1. Line activity with no tick starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | Receive-time enable, 16 per bit period |
| rx_in | input | 1 | Serial line, already synchronous to `clk` |
| long_char | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| rx_word | output | 9 | Last received character |
| rx_valid | output | 1 | One-cycle strobe when a character is delivered |
| noise_err | output | 1 | Sample disagreement in the delivered character |
| frame_err | output | 1 | Stop bit read as 0 in the delivered character |

## Verification
The assertions check several properties on every cycle. The strobe lasts one cycle and only follows an RT tick. Word and flags hold between strobes. The ninth bit is zero in 8-bit mode. The phase stays in range. The idle state cannot be left without a tick. The bench scenarios are needed for everything that depends on the shape of a whole frame. That covers the bit order and the majority vote, the exact tick at which the stop bit is decided, and the rejection of a false start. It also covers the noise and framing flags, and whether realignment actually rescues frames sent 6% slow or fast.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic decide;
        logic value;
        logic noisy;
    } bit_vote_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/uart_os_edge.sv
module uart_os_edge (
    input  logic clk,
    input  logic rst,
    input  logic rt_tick,
    input  logic rx_in,
    output logic fall
);
    logic last_lvl;

    always_ff @(posedge clk) begin
        if (rst)
            last_lvl <= 1'b1;
        else if (rt_tick)
            last_lvl <= rx_in;
    end

    assign fall = rt_tick & last_lvl & ~rx_in;
endmodule

// File: rtl/uart_os_phase.sv
module uart_os_phase #(
    parameter  int RT_PER_BIT = 16,
    localparam int CW         = $clog2(RT_PER_BIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rt_tick,
    input  logic          busy,
    input  logic          start_go,
    input  logic          fall,
    output logic [CW-1:0] rt_now,
    output logic          bit_adv
);
    localparam logic [CW-1:0] PH_ONE  = CW'(1);
    localparam logic [CW-1:0] PH_LAST = CW'(RT_PER_BIT);
    localparam logic [CW-1:0] WIN_LO  = CW'(RT_PER_BIT / 2);
    localparam logic [CW-1:0] WIN_HI  = CW'(RT_PER_BIT / 2 + 2);

    logic [CW-1:0] ph_q;
    logic [CW-1:0] ph_nat;

    always_comb begin
        ph_nat  = (ph_q == PH_LAST) ? PH_ONE : ph_q + PH_ONE;
        rt_now  = ph_nat;
        bit_adv = 1'b0;
        if (busy && rt_tick) begin
            if (ph_nat == PH_ONE)
                bit_adv = 1'b1;
            if (fall && (ph_nat < WIN_LO || ph_nat > WIN_HI)) begin
                rt_now = PH_ONE;
                if (ph_nat > WIN_HI)
                    bit_adv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_ONE;
        else if (start_go)
            ph_q <= PH_ONE;
        else if (busy && rt_tick)
            ph_q <= rt_now;
    end
endmodule

// File: rtl/uart_os_vote.sv
module uart_os_vote
    import uart_os_pkg::*;
#(
    parameter  int RT_PER_BIT = 16,
    localparam int CW         = $clog2(RT_PER_BIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rt_tick,
    input  logic          busy,
    input  logic [CW-1:0] rt_now,
    input  logic          rx_in,
    output bit_vote_t     vote
);
    localparam logic [CW-1:0] PH_A = CW'(RT_PER_BIT / 2);
    localparam logic [CW-1:0] PH_B = CW'(RT_PER_BIT / 2 + 1);
    localparam logic [CW-1:0] PH_C = CW'(RT_PER_BIT / 2 + 2);

    logic smp_a, smp_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (busy && rt_tick) begin
            if (rt_now == PH_A) smp_a <= rx_in;
            if (rt_now == PH_B) smp_b <= rx_in;
        end
    end

    always_comb begin
        vote.decide = busy && rt_tick && (rt_now == PH_C);
        vote.value  = maj3(smp_a, smp_b, rx_in);
        vote.noisy  = split3(smp_a, smp_b, rx_in);
    end
endmodule

// File: rtl/uart_os_ctrl.sv
module uart_os_ctrl
    import uart_os_pkg::*;
#(
    parameter  int DATA_W = 9,
    localparam int IW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_go,
    input  logic              long_char,
    input  bit_vote_t         vote,
    input  logic              bit_adv,
    output logic              busy,
    output logic              frame_long,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              noise_err,
    output logic              frame_err
);
    localparam logic [IW-1:0] IDX_LONG  = IW'(DATA_W - 1);
    localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_W - 2);

    rx_state_e         state;
    logic [IW-1:0]     bit_idx;
    logic [DATA_W-1:0] data_sr;
    logic              noise_acc;
    logic [IW-1:0]     last_idx;

    assign busy     = (state != RX_IDLE);
    assign last_idx = frame_long ? IDX_LONG : IDX_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_idx    <= '0;
            data_sr    <= '0;
            noise_acc  <= 1'b0;
            frame_long <= 1'b0;
            rx_word    <= '0;
            rx_valid   <= 1'b0;
            noise_err  <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (start_go) begin
                        state      <= RX_START;
                        bit_idx    <= '0;
                        data_sr    <= '0;
                        noise_acc  <= 1'b0;
                        frame_long <= long_char;
                    end
                end
                RX_START: begin
                    if (vote.decide) begin
                        noise_acc <= vote.noisy;
                        if (vote.value)
                            state <= RX_IDLE;
                    end else if (bit_adv) begin
                        state <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (vote.decide) begin
                        data_sr[bit_idx] <= vote.value;
                        noise_acc        <= noise_acc | vote.noisy;
                    end else if (bit_adv) begin
                        if (bit_idx == last_idx)
                            state <= RX_STOP;
                        else
                            bit_idx <= bit_idx + IW'(1);
                    end
                end
                RX_STOP: begin
                    if (vote.decide) begin
                        rx_word   <= data_sr;
                        noise_err <= noise_acc | vote.noisy;
                        frame_err <= ~vote.value;
                        rx_valid  <= 1'b1;
                        state     <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_pkg::*;
#(
    parameter  int RT_PER_BIT = 16,
    parameter  int DATA_W     = 9,
    localparam int CW         = $clog2(RT_PER_BIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rt_tick,
    input  logic              rx_in,
    input  logic              long_char,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              noise_err,
    output logic              frame_err
);
    logic          fall;
    logic          busy;
    logic          start_go;
    logic          bit_adv;
    logic          frame_long;
    logic [CW-1:0] rt_now;
    bit_vote_t     vote;

    assign start_go = fall & ~busy;

    uart_os_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .rt_tick (rt_tick),
        .rx_in   (rx_in),
        .fall    (fall)
    );

    uart_os_phase #(.RT_PER_BIT(RT_PER_BIT)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .rt_tick  (rt_tick),
        .busy     (busy),
        .start_go (start_go),
        .fall     (fall),
        .rt_now   (rt_now),
        .bit_adv  (bit_adv)
    );

    uart_os_vote #(.RT_PER_BIT(RT_PER_BIT)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .rt_tick (rt_tick),
        .busy    (busy),
        .rt_now  (rt_now),
        .rx_in   (rx_in),
        .vote    (vote)
    );

    uart_os_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_go   (start_go),
        .long_char  (long_char),
        .vote       (vote),
        .bit_adv    (bit_adv),
        .busy       (busy),
        .frame_long (frame_long),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .noise_err  (noise_err),
        .frame_err  (frame_err)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
    parameter  int RT_PER_BIT = 16,
    parameter  int DATA_W     = 9,
    localparam int CW         = $clog2(RT_PER_BIT + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              rt_tick,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_word,
    input logic              noise_err,
    input logic              frame_err,
    input logic              busy,
    input logic              frame_long,
    input logic [CW-1:0]     rt_now
);
    a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r11_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rt_tick));

    a_r10_word_held: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    a_r10_flags_held: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable({noise_err, frame_err}));

    a_r11_idle_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rt_tick) |=> !busy);

    a_r4_short_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !frame_long) |-> (rx_word[DATA_W-1] == 1'b0));

    a_r8_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        (busy && rt_tick) |-> (rt_now >= CW'(1) && rt_now <= CW'(RT_PER_BIT)));
endmodule

bind uart_os_rx uart_os_rx_chk #(.RT_PER_BIT(RT_PER_BIT), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rt_tick    (rt_tick),
    .rx_valid   (rx_valid),
    .rx_word    (rx_word),
    .noise_err  (noise_err),
    .frame_err  (frame_err),
    .busy       (busy),
    .frame_long (frame_long),
    .rt_now     (rt_now)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rt_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       long_char = 1'b0;
    logic [8:0] rx_word;
    logic       rx_valid;
    logic       noise_err;
    logic       frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int tick_no = 0;
    int start_tick = 0;
    int valid_tick = 0;
    int vcount = 0;
    logic [8:0] cap_word;
    logic       cap_noise, cap_frame;

    always #5 clk = ~clk;

    uart_os_rx u0 (
        .clk(clk), .rst(rst), .rt_tick(rt_tick), .rx_in(rx_in),
        .long_char(long_char), .rx_word(rx_word), .rx_valid(rx_valid),
        .noise_err(noise_err), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            vcount     <= vcount + 1;
            valid_tick <= tick_no;
            cap_word   <= rx_word;
            cap_noise  <= noise_err;
            cap_frame  <= frame_err;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic lvl);
        @(negedge clk);
        rx_in   = lvl;
        rt_tick = 1'b1;
        tick_no++;
        @(negedge clk);
        rt_tick = 1'b0;
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) do_tick(1'b1);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic nine, input int len,
                              input int g_bit, input int g_rt, input logic stop_lvl);
        int nb;
        logic lvl;
        nb = nine ? 9 : 8;
        long_char = nine;
        for (int b = 0; b <= nb + 1; b++) begin
            lvl = (b == 0) ? 1'b0 : (b <= nb) ? d[b-1] : stop_lvl;
            for (int t = 0; t < len; t++) begin
                do_tick((b == g_bit && t == g_rt - 1) ? ~lvl : lvl);
                if (b == 0 && t == 0) start_tick = tick_no;
            end
        end
        idle_ticks(4);
    endtask

    task automatic t_reset;
        check("R10 reset word", rx_word, 0);
        check("R10 reset valid", rx_valid, 0);
        check("R10 reset noise", noise_err, 0);
        check("R10 reset frame", frame_err, 0);
    endtask

    task automatic t_nominal8;
        int v0 = vcount;
        send_frame(9'h0A5, 1'b0, 16, -1, 0, 1'b1);
        check("R1 one strobe", vcount - v0, 1);
        check("R4 R2 word lsb first", cap_word, 9'h0A5);
        check("R6 clean noise", cap_noise, 0);
        check("R7 clean frame", cap_frame, 0);
        check("R5 stop tick 8-bit", valid_tick - start_tick, 153);
        check("R10 word held", rx_word, 9'h0A5);
    endtask

    task automatic t_nine;
        int v0 = vcount;
        send_frame(9'h1A5, 1'b1, 16, -1, 0, 1'b1);
        check("R4 nine-bit strobe", vcount - v0, 1);
        check("R4 nine-bit word", cap_word, 9'h1A5);
        check("R5 stop tick 9-bit", valid_tick - start_tick, 169);
        send_frame(9'h1FF, 1'b0, 16, -1, 0, 1'b1);
        check("R4 short top bit 0", cap_word, 9'h0FF);
    endtask

    task automatic t_skew(input int len, input string tag);
        int v0 = vcount;
        send_frame(9'h055, 1'b0, len, -1, 0, 1'b1);
        check({"R9 R8 strobe ", tag}, vcount - v0, 1);
        check({"R9 R8 word ", tag}, cap_word, 9'h055);
        check({"R9 noise ", tag}, cap_noise, 0);
        check({"R9 frame ", tag}, cap_frame, 0);
    endtask

    task automatic t_noise;
        // data bit 3 of 0xC3 is 0, frame bit 4, flipped at phase 9
        send_frame(9'h0C3, 1'b0, 16, 4, 9, 1'b1);
        check("R2 majority survives glitch", cap_word, 9'h0C3);
        check("R6 noise set", cap_noise, 1);
        check("R7 no frame err", cap_frame, 0);
        send_frame(9'h03C, 1'b0, 16, -1, 0, 1'b1);
        check("R6 noise clears next frame", cap_noise, 0);
    endtask

    task automatic t_framing;
        send_frame(9'h081, 1'b0, 16, -1, 0, 1'b0);
        check("R7 frame err set", cap_frame, 1);
        check("R7 word delivered", cap_word, 9'h081);
        idle_ticks(20);
    endtask

    task automatic t_false_start;
        int v0 = vcount;
        for (int i = 0; i < 5; i++) do_tick(1'b0);
        idle_ticks(40);
        check("R3 no strobe on false start", vcount - v0, 0);
        send_frame(9'h03C, 1'b0, 16, -1, 0, 1'b1);
        check("R3 next frame ok", cap_word, 9'h03C);
    endtask

    task automatic t_no_tick;
        int v0 = vcount;
        @(negedge clk);
        rx_in = 1'b0;
        repeat (60) @(negedge clk);
        rx_in = 1'b1;
        idle_ticks(200);
        check("R11 no frame without tick", vcount - v0, 0);
        check("R11 word untouched", rx_word, 9'h03C);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        idle_ticks(3);
        t_nominal8();
        t_nine();
        t_skew(17, "slow");
        t_skew(15, "fast");
        t_noise();
        t_framing();
        t_false_start();
        t_no_tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule